// File: doc/BRIEF.md
# Status Flag Update Unit

This block keeps the condition and bank flags of an 8-bit processor's status word and updates them at the end of each executed operation. The execute stage tells it the operation class and supplies the two operands, the result, the carry (or borrow) coming into and out of the adder, the bit rotated out, the result of a single-bit operation and a two-bit bank number. On the next clock edge the unit stores the flags that class is allowed to touch and keeps every other flag as it was.

The carry flag has three jobs. Arithmetic writes the adder's carry or borrow into it. A rotate writes the bit that left the byte. A single-bit operation writes its one-bit result, so the flag can serve as an accumulator. The auxiliary flag is worked out inside the unit from the low nibbles of the operands. It marks a carry out of bit 3 on addition and a borrow at bit 3 on subtraction.

A restore input loads all stored flags at once, for example when a context is brought back after an interrupt handler. The two interrupt-control bits are not stored here. They pass straight into the packed status byte.

Top module: `flag_update_unit`

## Requirements
- R1: While `rst_ni` is low, and after it rises, all stored flags read 0 until the first update. `status_o` then equals `{1'b0, in_svc_i, int_en_i, 5'b0}`.
- R2: On add (`op_i`=1) or subtract (`op_i`=2), `zero_o` becomes 1 in the cycle after the edge if `res_i` is 0x00, and 0 otherwise.
- R3: On add (`op_i`=1), `aux_o` becomes the carry out of bit 3 of `a_i[3:0] + b_i[3:0] + cin_i`.
- R4: On subtract (`op_i`=2), `aux_o` becomes 1 exactly when `a_i[3:0] < b_i[3:0] + cin_i`. The comparison is unsigned and 5 bits wide.
- R5: On add or subtract, `carry_o` takes the value of `cout_i`.
- R6: On rotate (`op_i`=3), `carry_o` takes `rot_out_i`. Zero, auxiliary and bank flags keep their values.
- R7: On a bit operation (`op_i`=4), `carry_o` takes `bit_val_i`. Zero, auxiliary and bank flags keep their values.
- R8: On bank select (`op_i`=5), `bank_o` takes `bank_i`. Zero, auxiliary and carry keep their values.
- R9: On `op_i`=0, and on the unused codes 6 and 7, no stored flag changes, whatever the other data inputs carry.
- R10: When `ld_i` is high, all stored flags take `ld_flags_i` at the edge: bit 0 goes to carry, bit 1 to aux, bit 2 to zero and bits 4:3 to bank. The load wins over any `op_i`.
- R11: `status_o` packs the flags as follows: bit 0 carry, bit 1 aux, bit 2 zero, bits 4:3 bank, bit 5 `int_en_i`, bit 6 `in_svc_i`, bit 7 always 0. Bits 6:5 follow their inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation class (0 none, 1 add, 2 sub, 3 rotate, 4 bit op, 5 bank select) |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| res_i | input | 8 | Result of the operation |
| cin_i | input | 1 | Carry or borrow into the adder |
| cout_i | input | 1 | Carry or borrow out of the adder |
| rot_out_i | input | 1 | Bit shifted out by a rotate |
| bit_val_i | input | 1 | One-bit result of a bit operation |
| bank_i | input | 2 | Bank index for bank select |
| ld_i | input | 1 | Load all stored flags |
| ld_flags_i | input | 5 | Flag values to load, in `status_o[4:0]` layout |
| int_en_i | input | 1 | Interrupt-enable bit, passed through |
| in_svc_i | input | 1 | In-service priority bit, passed through |
| zero_o | output | 1 | Zero flag |
| aux_o | output | 1 | Auxiliary carry flag |
| carry_o | output | 1 | Carry flag |
| bank_o | output | 2 | Bank select flags |
| status_o | output | 8 | Packed status byte |

## Verification
Each stored flag reaches the ports one cycle after the edge that writes it. A wrong next-state choice therefore shows up in the very next cycle as one wrong bit in `status_o`, and it stays there until some later operation overwrites that flag. The scoreboard therefore follows each arithmetic operation with rotates, bit operations, bank selects and idle cycles. A flag that one of these classes wrongly disturbs, or fails to keep, then differs from the model at the next comparison. Loads that come together with a competing operation show whether the restore path really has priority.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned FLAG_W = 5;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_ROT  = 3'd3,
    OP_BIT  = 3'd4,
    OP_BANK = 3'd5
  } op_e;

  // packed order gives status byte bits [4:0]
  typedef struct packed {
    logic [1:0] bank;
    logic       zero;
    logic       aux;
    logic       carry;
  } flags_t;
endpackage

// File: rtl/flag_arith.sv
module flag_arith #(
  parameter int unsigned DW = 8,
  parameter int unsigned NW = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] res_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic          zero_o,
  output logic          aux_o
);
  localparam int unsigned SW = NW + 1;

  logic [SW-1:0] a_lo, b_lo, sum_lo, sub_rhs;
  logic          unused_hi;

  assign a_lo    = {1'b0, a_i[NW-1:0]};
  assign b_lo    = {1'b0, b_i[NW-1:0]};
  assign sum_lo  = a_lo + b_lo + SW'(cin_i);
  assign sub_rhs = b_lo + SW'(cin_i);

  assign zero_o  = (res_i == '0);
  assign aux_o   = sub_i ? (a_lo < sub_rhs) : sum_lo[NW];

  assign unused_hi = ^{a_i[DW-1:NW], b_i[DW-1:NW]};
endmodule

// File: rtl/flag_next.sv
module flag_next
  import flag_pkg::*;
(
  input  flags_t     cur_i,
  input  logic [2:0] op_i,
  input  logic       ld_i,
  input  flags_t     ld_val_i,
  input  logic       zero_i,
  input  logic       aux_i,
  input  logic       cout_i,
  input  logic       rot_out_i,
  input  logic       bit_val_i,
  input  logic [1:0] bank_i,
  output flags_t     nxt_o
);
  op_e op;
  assign op = op_e'(op_i);

  always_comb begin
    nxt_o = cur_i;
    if (ld_i) begin
      nxt_o = ld_val_i;
    end else begin
      case (op)
        OP_ADD, OP_SUB: begin
          nxt_o.zero  = zero_i;
          nxt_o.aux   = aux_i;
          nxt_o.carry = cout_i;
        end
        OP_ROT:  nxt_o.carry = rot_out_i;
        OP_BIT:  nxt_o.carry = bit_val_i;
        OP_BANK: nxt_o.bank  = bank_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import flag_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/flag_update_unit.sv
module flag_update_unit
  import flag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              cin_i,
  input  logic              cout_i,
  input  logic              rot_out_i,
  input  logic              bit_val_i,
  input  logic [1:0]        bank_i,
  input  logic              ld_i,
  input  logic [FLAG_W-1:0] ld_flags_i,
  input  logic              int_en_i,
  input  logic              in_svc_i,
  output logic              zero_o,
  output logic              aux_o,
  output logic              carry_o,
  output logic [1:0]        bank_o,
  output logic [DATA_W-1:0] status_o
);
  localparam int unsigned PAD_W = DATA_W - FLAG_W - 2;

  flags_t cur, nxt;
  logic   ar_zero, ar_aux;

  flag_arith #(.DW(DATA_W), .NW(NIB_W)) i_arith (
    .a_i    (a_i),
    .b_i    (b_i),
    .res_i  (res_i),
    .cin_i  (cin_i),
    .sub_i  (op_i == OP_SUB),
    .zero_o (ar_zero),
    .aux_o  (ar_aux)
  );

  flag_next i_next (
    .cur_i     (cur),
    .op_i      (op_i),
    .ld_i      (ld_i),
    .ld_val_i  (flags_t'(ld_flags_i)),
    .zero_i    (ar_zero),
    .aux_i     (ar_aux),
    .cout_i    (cout_i),
    .rot_out_i (rot_out_i),
    .bit_val_i (bit_val_i),
    .bank_i    (bank_i),
    .nxt_o     (nxt)
  );

  flag_reg i_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (nxt),
    .q_o    (cur)
  );

  assign zero_o   = cur.zero;
  assign aux_o    = cur.aux;
  assign carry_o  = cur.carry;
  assign bank_o   = cur.bank;
  assign status_o = {{PAD_W{1'b0}}, in_svc_i, int_en_i, cur};

  AST_ARITH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && (op_i == OP_ADD || op_i == OP_SUB)) |=> (zero_o == ($past(res_i) == '0))); // R2
  AST_ARITH_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && (op_i == OP_ADD || op_i == OP_SUB)) |=> (carry_o == $past(cout_i))); // R5
  AST_ROT_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && op_i == OP_ROT) |=> (carry_o == $past(rot_out_i) && $stable(bank_o) && $stable(zero_o) && $stable(aux_o))); // R6
  AST_BIT_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && op_i == OP_BIT) |=> (carry_o == $past(bit_val_i) && $stable(bank_o) && $stable(zero_o) && $stable(aux_o))); // R7
  AST_BANK_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && op_i == OP_BANK) |=> (bank_o == $past(bank_i) && $stable(carry_o) && $stable(zero_o) && $stable(aux_o))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && (op_i == OP_NONE || op_i > OP_BANK)) |=> $stable(status_o[FLAG_W-1:0])); // R9
  AST_LOAD_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (status_o[FLAG_W-1:0] == $past(ld_flags_i))); // R10
  AST_TOP_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[DATA_W-1] == 1'b0); // R11
endmodule

// File: tb/test_flag_update_unit.sv
module test_flag_update_unit;
  logic       clk = 0, rst_n = 0;
  logic [2:0] op = 0;
  logic [7:0] a = 0, b = 0, res = 0;
  logic       cin = 0, cout = 0, rot = 0, bitv = 0, ld = 0, ie = 0, is = 0;
  logic [1:0] bank = 0;
  logic [4:0] ldv = 0;
  logic       z_o, ac_o, cy_o;
  logic [1:0] bk_o;
  logic [7:0] st_o;

  always #10 clk = ~clk;

  flag_update_unit i_flag_update_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .b_i(b), .res_i(res),
    .cin_i(cin), .cout_i(cout), .rot_out_i(rot), .bit_val_i(bitv),
    .bank_i(bank), .ld_i(ld), .ld_flags_i(ldv), .int_en_i(ie), .in_svc_i(is),
    .zero_o(z_o), .aux_o(ac_o), .carry_o(cy_o), .bank_o(bk_o), .status_o(st_o));

  typedef struct { logic [7:0] exp; string req; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  logic m_z = 0, m_ac = 0, m_cy = 0;
  logic [1:0] m_bk = 0;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] o, input logic [7:0] ia, input logic [7:0] ib,
                      input logic [7:0] ir, input logic ic, input logic ico,
                      input logic ir_o, input logic ibv, input logic [1:0] ibk,
                      input logic il, input logic [4:0] ilv, input logic iie,
                      input logic iis, input string req);
    logic [4:0] sl, br;
    item_t it;
    @(negedge clk);
    op = o; a = ia; b = ib; res = ir; cin = ic; cout = ico; rot = ir_o;
    bitv = ibv; bank = ibk; ld = il; ldv = ilv; ie = iie; is = iis;
    if (il) begin
      {m_bk, m_z, m_ac, m_cy} = ilv;
    end else begin
      case (o)
        3'd1: begin
          sl = {1'b0, ia[3:0]} + {1'b0, ib[3:0]} + {4'b0, ic};
          m_z = (ir == 0); m_ac = sl[4]; m_cy = ico;
        end
        3'd2: begin
          br = {1'b0, ib[3:0]} + {4'b0, ic};
          m_z = (ir == 0); m_ac = ({1'b0, ia[3:0]} < br); m_cy = ico;
        end
        3'd3: m_cy = ir_o;
        3'd4: m_cy = ibv;
        3'd5: m_bk = ibk;
        default: ;
      endcase
    end
    it.exp = {1'b0, iis, iie, m_bk, m_z, m_ac, m_cy};
    it.req = req;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        check(it.req, st_o, it.exp);
        check({it.req, " ports"}, {3'b0, bk_o, z_o, ac_o, cy_o}, {3'b0, it.exp[4:0]});
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : driver
    #5;
    check("R1 in reset", st_o, 8'h00);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    ie = 1; is = 1;
    #1 check("R1 after release", st_o, 8'h60);
    check("R11 passthrough", st_o, 8'h60);
    // R3 add with carry out of bit 3
    step(1, 8'h0F, 8'h01, 8'h10, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 add nibble carry");
    step(1, 8'hFF, 8'h01, 8'h00, 0, 1, 0, 0, 0, 0, 0, 1, 0, "R2 R5 add zero carry");
    step(1, 8'h08, 8'h07, 8'h10, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R3 add cin into bit 3");
    step(1, 8'h12, 8'h03, 8'h15, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 add no nibble carry");
    step(2, 8'h10, 8'h01, 8'h0F, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 sub nibble borrow");
    step(2, 8'h05, 8'h05, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 R4 sub equal");
    step(2, 8'h35, 8'h05, 8'h2F, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R4 sub borrow in");
    step(2, 8'h01, 8'h02, 8'hFF, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R5 sub borrow out");
    step(3, 8'h00, 8'h00, 8'h00, 0, 1, 0, 1, 3, 0, 0, 0, 0, "R6 rotate out 0");
    step(3, 8'hFF, 8'hFF, 8'h00, 1, 0, 1, 0, 2, 0, 0, 0, 0, "R6 rotate out 1");
    step(4, 8'h00, 8'h00, 8'h00, 1, 1, 1, 0, 1, 0, 0, 0, 0, "R7 bit op 0");
    step(4, 8'h00, 8'h00, 8'h00, 0, 0, 0, 1, 3, 0, 0, 0, 0, "R7 bit op 1");
    step(5, 8'h00, 8'h0F, 8'h00, 1, 0, 0, 0, 2, 0, 0, 0, 0, "R8 bank 2");
    step(5, 8'hF0, 8'h0F, 8'h00, 0, 0, 0, 0, 1, 0, 0, 1, 1, "R8 bank 1");
    step(0, 8'h0F, 8'h01, 8'h00, 1, 1, 1, 1, 3, 0, 0, 0, 0, "R9 idle");
    step(6, 8'h0F, 8'h01, 8'h00, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R9 code 6");
    step(7, 8'h01, 8'h0F, 8'h00, 0, 1, 1, 1, 2, 0, 0, 1, 0, "R9 code 7");
    step(0, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 0, 1, 5'b10101, 0, 0, "R10 load");
    step(1, 8'h0F, 8'h01, 8'h00, 0, 1, 0, 0, 0, 1, 5'b01010, 1, 0, "R10 load beats add");
    step(5, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 3, 1, 5'b00000, 0, 1, "R10 load beats bank");
    step(3, 8'h00, 8'h00, 8'h00, 0, 0, 1, 0, 0, 0, 0, 1, 1, "R6 R11 rotate after load");
    @(negedge clk);
    op = 0; ld = 0;
    wait (q.size() == 0);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule